// File: doc/BRIEF.md
# Serial ADC Control Sequencer

This block is the digital controller of an 8-bit successive-approximation converter. It runs on a free-running internal clock. A host reaches it through an asynchronous active-low chip select and a serial shift clock. While the host holds the select low, the block puts the previously converted code on a serial data line, most significant bit first. It opens a sampling window on the analog front end partway through each eight-edge transfer, and ends that window with a hold. It then runs a binary search against a one-bit comparator to produce the next code.

Each transfer both reads the last result and starts a new conversion. The select may stay low across many transfers, in which case the edge counter simply wraps. If the select is re-recognised low during a conversion, the conversion is cancelled. A fresh eight-edge transfer during a conversion also abandons it and starts another one. In both cases the stored result is left as it was.

Top module: `sadc_seq`

## Requirements
- R1: While `cs_n` is high, `dout_en` is 0 and edges on `ioclk` have no effect: no sampling, no conversion, and the edge count does not advance.
- R2: A low level on `cs_n` is accepted only after two synchroniser stages plus `CS_QUAL` further internal cycles of steady low. `dout_en` then goes to 1. A rise on `cs_n` drops `dout_en` with no clock involved.
- R3: Once the select is accepted, `dout` shows bit 7 of the stored result. Falls 1 to 7 of `ioclk` each advance `dout` one bit towards bit 0.
- R4: `samp_en` is 1 from the 4th `ioclk` fall of a transfer until the 8th fall, and 0 otherwise.
- R5: The 8th fall starts `HOLD_CYC` (4) internal cycles with `hold_en` at 1. Eight bit slots of `BIT_CYC` (4) cycles follow. `busy` is 1 for the whole 36 cycles, and the result register is written at the end.
- R6: In each slot the block drives a trial code on `dac_code`. It reads `cmp`, where 1 means the input is at or above the trial code, and keeps or clears that bit, from bit 7 down to bit 0. Inputs above full scale give 8'hFF and inputs below zero give 8'h00.
- R7: Re-accepting the select during a conversion cancels it (`busy` falls) and leaves the stored result unchanged.
- R8: Eight new falls during a conversion abandon it and start a new one. The bits shifted out in that transfer are the older stored result.
- R9: With the select held low, the edge count wraps after eight falls. The next transfer after a conversion completes shifts out the new result.
- R10: After reset, `busy`, `samp_en`, `hold_en`, `dout_en` and `dac_code` are 0 and the stored result is 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal system clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Asynchronous active-low chip select |
| ioclk | input | 1 | Asynchronous serial shift clock from the host |
| cmp | input | 1 | Comparator decision: input at or above `dac_code` |
| dout | output | 1 | Serial result bit |
| dout_en | output | 1 | Output-driver enable; 0 means high impedance |
| samp_en | output | 1 | Sampling switch enable to the analog front end |
| hold_en | output | 1 | Hold phase indicator |
| busy | output | 1 | Conversion in progress |
| dac_code | output | DW | Trial code presented to the comparator |

## Verification
The bench attacks the two ways a conversion can be cut short: a select re-acceptance and a rapid second eight-edge transfer. A design that wrote a partial code, or let the abandoned conversion finish, would shift out a wrong value in the next transfer. Out-of-range inputs are driven to check saturation, since a search that mishandled the top or bottom bit would return a code that is off by one step. Edges sent with the select high test that the counter is gated; a leak would misalign every later word. Back-to-back transfers with the select held low test counter wrap and the reload of the new result.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

    localparam int DATA_W    = 8;
    localparam int QUAL_CYC  = 3;
    localparam int HOLD_LEN  = 4;
    localparam int SLOT_LEN  = 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HOLD = 2'd1,
        ST_CONV = 2'd2
    } sar_st_t;

    typedef struct packed {
        logic fall;
        logic last;
        logic open_win;
    } io_evt_t;

endpackage

// File: rtl/sadc_sync.sv
module sadc_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    input  logic [W-1:0] rst_val,
    output logic [W-1:0] q
);
    logic [W-1:0] s1;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= rst_val;
            q  <= rst_val;
        end else begin
            s1 <= d;
            q  <= s1;
        end
    end
endmodule

// File: rtl/sadc_csfilt.sv
module sadc_csfilt #(
    parameter int QUAL = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_n_s,
    output logic cs_act,
    output logic cs_start
);
    localparam int QW = $clog2(QUAL + 1);

    logic [QW-1:0] lo_cnt;

    always_ff @(posedge clk) begin
        if (rst || cs_n_s) begin
            lo_cnt   <= '0;
            cs_act   <= 1'b0;
            cs_start <= 1'b0;
        end else if (!cs_act) begin
            if (lo_cnt == QW'(QUAL - 1)) begin
                cs_act   <= 1'b1;
                cs_start <= 1'b1;
            end else begin
                lo_cnt   <= lo_cnt + 1'b1;
                cs_start <= 1'b0;
            end
        end else begin
            cs_start <= 1'b0;
        end
    end
endmodule

// File: rtl/sadc_sar.sv
module sadc_sar
    import sadc_pkg::*;
#(
    parameter int DW       = 8,
    parameter int HOLD_CYC = 4,
    parameter int BIT_CYC  = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          abort,
    input  logic          cmp,
    output logic          hold_en,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] result,
    output logic [DW-1:0] dac_code
);
    localparam int TMAX = (HOLD_CYC > BIT_CYC) ? HOLD_CYC : BIT_CYC;
    localparam int TW   = $clog2(TMAX) + 1;
    localparam int BW   = $clog2(DW);

    sar_st_t       st;
    logic [TW-1:0] tmr;
    logic [BW-1:0] idx;
    logic [DW-1:0] code;
    logic [DW-1:0] kept;
    logic [DW-1:0] trial_nxt;
    logic          slot_end;

    // keep or clear the bit under test, then raise the next one
    always_comb begin
        kept = code;
        if (!cmp) kept[idx] = 1'b0;
        trial_nxt = kept;
        if (idx != '0) trial_nxt[idx - 1'b1] = 1'b1;
    end

    assign slot_end = (st == ST_CONV) && (tmr == TW'(BIT_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            tmr    <= '0;
            idx    <= '0;
            code   <= '0;
            result <= '0;
            done   <= 1'b0;
        end else if (start) begin
            st   <= ST_HOLD;
            tmr  <= '0;
            code <= '0;
            done <= 1'b0;
        end else if (abort) begin
            st   <= ST_IDLE;
            tmr  <= '0;
            code <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                ST_HOLD: begin
                    if (tmr == TW'(HOLD_CYC - 1)) begin
                        st   <= ST_CONV;
                        tmr  <= '0;
                        idx  <= BW'(DW - 1);
                        code <= {1'b1, {(DW-1){1'b0}}};
                    end else begin
                        tmr <= tmr + 1'b1;
                    end
                end
                ST_CONV: begin
                    if (slot_end) begin
                        tmr <= '0;
                        if (idx == '0) begin
                            result <= kept;
                            code   <= '0;
                            st     <= ST_IDLE;
                            done   <= 1'b1;
                        end else begin
                            code <= trial_nxt;
                            idx  <= idx - 1'b1;
                        end
                    end else begin
                        tmr <= tmr + 1'b1;
                    end
                end
                default: tmr <= '0;
            endcase
        end
    end

    assign busy     = (st != ST_IDLE);
    assign hold_en  = (st == ST_HOLD);
    assign dac_code = code;
endmodule

// File: rtl/sadc_seq.sv
module sadc_seq
    import sadc_pkg::*;
#(
    parameter int DW       = DATA_W,
    parameter int CS_QUAL  = QUAL_CYC,
    parameter int HOLD_CYC = HOLD_LEN,
    parameter int BIT_CYC  = SLOT_LEN
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cs_n,
    input  logic          ioclk,
    input  logic          cmp,
    output logic          dout,
    output logic          dout_en,
    output logic          samp_en,
    output logic          hold_en,
    output logic          busy,
    output logic [DW-1:0] dac_code
);
    localparam int EDGES     = DW;
    localparam int CW        = $clog2(EDGES);
    localparam int SAMP_EDGE = EDGES / 2;

    logic [1:0]    sync_q;
    logic          cs_n_s;
    logic          io_s;
    logic          io_prev;
    logic          cs_act;
    logic          cs_start;
    logic [CW-1:0] edge_cnt;
    logic [DW-1:0] shreg;
    logic [DW-1:0] sar_result;
    logic          sar_done;
    io_evt_t       ev;

    sadc_sync #(.W(2)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d       ({cs_n, ioclk}),
        .rst_val (2'b10),
        .q       (sync_q)
    );
    assign cs_n_s = sync_q[1];
    assign io_s   = sync_q[0];

    sadc_csfilt #(.QUAL(CS_QUAL)) u_csf (
        .clk      (clk),
        .rst      (rst),
        .cs_n_s   (cs_n_s),
        .cs_act   (cs_act),
        .cs_start (cs_start)
    );

    always_comb begin
        ev.fall     = cs_act && io_prev && !io_s;
        ev.last     = ev.fall && (edge_cnt == CW'(EDGES - 1));
        ev.open_win = ev.fall && (edge_cnt == CW'(SAMP_EDGE - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            io_prev  <= 1'b0;
            edge_cnt <= '0;
            samp_en  <= 1'b0;
            shreg    <= '0;
        end else begin
            io_prev <= io_s;

            if (!cs_act)      edge_cnt <= '0;
            else if (ev.last) edge_cnt <= '0;
            else if (ev.fall) edge_cnt <= edge_cnt + 1'b1;

            if (!cs_act || ev.last) samp_en <= 1'b0;
            else if (ev.open_win)   samp_en <= 1'b1;

            if (cs_start || ev.last)
                shreg <= sar_result;
            else if (ev.fall)
                shreg <= {shreg[DW-2:0], 1'b0};
            else if (sar_done && cs_act && edge_cnt == '0)
                shreg <= sar_result;
        end
    end

    sadc_sar #(
        .DW       (DW),
        .HOLD_CYC (HOLD_CYC),
        .BIT_CYC  (BIT_CYC)
    ) u_sar (
        .clk      (clk),
        .rst      (rst),
        .start    (ev.last),
        .abort    (cs_start),
        .cmp      (cmp),
        .hold_en  (hold_en),
        .busy     (busy),
        .done     (sar_done),
        .result   (sar_result),
        .dac_code (dac_code)
    );

    assign dout    = shreg[DW-1];
    assign dout_en = cs_act && !cs_n;
endmodule

// File: rtl/sadc_seq_chk.sv
module sadc_seq_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          samp_en,
    input logic          hold_en,
    input logic          busy,
    input logic [DW-1:0] result
);
    // R5
    hold_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
        hold_en |-> busy);

    // R4
    samp_hold_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(samp_en && hold_en));

    // R4
    samp_before_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(hold_en) |-> $past(samp_en));

    // R5
    busy_starts_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> hold_en);

    // R7
    result_on_finish_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(result) |-> $fell(busy));
endmodule

bind sadc_seq sadc_seq_chk #(.DW(DW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .samp_en (samp_en),
    .hold_en (hold_en),
    .busy    (busy),
    .result  (sar_result)
);

// File: tb/sadc_seq_test.sv
module sadc_seq_test;
    logic       clk = 1'b0;
    logic       rst;
    logic       cs_n;
    logic       ioclk;
    logic       cmp;
    logic       dout;
    logic       dout_en;
    logic       samp_en;
    logic       hold_en;
    logic       busy;
    logic [7:0] dac_code;
    int         ain;
    int         n_run  = 0;
    int         n_fail = 0;
    bit         finished = 0;

    localparam int NV = 8;
    // analog level, expected clamped code (R6)
    localparam int VEC_AIN[NV] = '{100, 300, -7, 255, 0, 170, 85, 1};
    localparam int VEC_EXP[NV] = '{100, 255,  0, 255, 0, 170, 85, 1};

    always #5 clk = ~clk;

    assign cmp = (ain >= int'(dac_code));

    sadc_seq uut (
        .clk      (clk),
        .rst      (rst),
        .cs_n     (cs_n),
        .ioclk    (ioclk),
        .cmp      (cmp),
        .dout     (dout),
        .dout_en  (dout_en),
        .samp_en  (samp_en),
        .hold_en  (hold_en),
        .busy     (busy),
        .dac_code (dac_code)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // eight ioclk pulses; bit 7-k is sampled just before fall k+1
    task automatic xfer(input int half, input bit win, output logic [7:0] got);
        for (int k = 0; k < 8; k++) begin
            ioclk = 1'b1;
            tick(half);
            got[7-k] = dout;
            if (win && k == 3) check("R4 closed before 4th fall", samp_en, 0);
            if (win && k == 4) check("R4 open after 4th fall", samp_en, 1);
            ioclk = 1'b0;
            if (k < 7) tick(half);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] got;
        int prev;
        rst = 1'b1; cs_n = 1'b1; ioclk = 1'b0; ain = 0;
        tick(5);
        rst = 1'b0;
        tick(2);
        // R10 reset state
        check("R10 busy", busy, 0);
        check("R10 samp_en", samp_en, 0);
        check("R10 hold_en", hold_en, 0);
        check("R10 dac_code", dac_code, 0);
        check("R1 dout_en with cs high", dout_en, 0);

        prev = 0;
        for (int i = 0; i < NV; i++) begin
            ain  = VEC_AIN[i];
            cs_n = 1'b0;
            tick(10);
            check("R2 enabled after filter", dout_en, 1);
            xfer(4, 1'b1, got);
            check("R3 R6 shifted word", got, prev);
            tick(5);
            check("R4 closed after 8th fall", samp_en, 0);
            check("R5 hold active", hold_en, 1);
            check("R5 busy active", busy, 1);
            tick(40);
            check("R5 busy done", busy, 0);
            check("R5 hold done", hold_en, 0);
            cs_n = 1'b1;
            #1;
            check("R2 immediate tri-state", dout_en, 0);
            tick(3);
            prev = VEC_EXP[i];
        end

        // R1: ioclk edges with cs high are ignored
        ain = 200;
        for (int k = 0; k < 8; k++) begin
            ioclk = 1'b1; tick(4);
            ioclk = 1'b0; tick(4);
        end
        check("R1 no busy", busy, 0);
        check("R1 no sample", samp_en, 0);
        cs_n = 1'b0;
        tick(10);
        xfer(4, 1'b0, got);
        check("R1 word aligned", got, 1);
        tick(45);

        // R9: select held low, counter wraps, new result reloaded
        ain = 210;
        tick(4);
        xfer(4, 1'b0, got);
        check("R9 continuous word", got, 200);
        tick(45);

        // R8: second transfer during a conversion restarts it
        ain = 60;
        xfer(2, 1'b0, got);
        tick(2);
        check("R8 first word", got, 210);
        ain = 90;
        xfer(2, 1'b0, got);
        check("R8 older result shifted", got, 210);
        tick(45);
        check("R8 idle after restart", busy, 0);
        tick(4);
        xfer(4, 1'b0, got);
        check("R8 restarted conversion result", got, 90);
        tick(45);

        // R7: re-accepted select cancels the conversion
        ain = 33;
        tick(4);
        xfer(4, 1'b0, got);
        check("R7 word before abort", got, 90);
        tick(6);
        check("R7 busy before abort", busy, 1);
        cs_n = 1'b1;
        tick(3);
        cs_n = 1'b0;
        tick(8);
        check("R7 busy cleared", busy, 0);
        tick(40);
        xfer(4, 1'b0, got);
        check("R7 result kept", got, 90);
        tick(45);
        cs_n = 1'b1;
        tick(3);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule